// File: doc/BRIEF.md
# Serial Converter Interface Model

This block is a cycle-based, synthesizable stand-in for the digital side of a differential sampling converter with a three-wire serial port. A host controller drives a convert strobe and a serial clock into it. The block then behaves as the real converter's timing logic would. A parallel input word stands in for the analog signal: it is captured when a conversion starts, and it is returned to the host in the frame that follows.

All inputs are sampled on the system clock `clk`, and an event on the strobe or the serial clock is a 0-to-1 change between two samples. The serial output is a data bit plus an output enable. When the enable is low, the line is in high impedance. The block also reports its internal state to the host's test environment: the sample/hold state, the two low-power states, a reference-ready flag and a protocol-violation flag.

The first strobe that follows a serial clock edge starts a conversion. Further strobes that arrive with no serial clock activity in between act as power commands. The first serial clock edge after such a run returns the block to normal operation.

Top module: `adc_serial_model`

## Requirements
- R1: After reset, sdo_oe, hold, nap, sleep and proto_err are 0, ref_ready is 1, and the stored result word is 0.
- R2: A conv rise that is the first since the last sck rise (or since reset) sets hold and sdo_oe in the next cycle. It captures sample_in, and sdo_data then carries the most significant bit of the frame word.
- R3: The frame word is the 16-bit value {result, zeros}: the RES_BITS-bit two's-complement result sits in the upper bits, sign bit first, and every slot after the LSB carries 0. Each sck rise during a frame advances sdo_data by one slot.
- R4: The 16th sck rise of a frame clears sdo_oe and hold. A later sck rise outside a frame leaves sdo_oe at 0.
- R5: The word sent in a frame is the sample captured by the most recent frame that received all 16 sck rises, not the sample captured by the current strobe.
- R6: Two conv rises with no sck rise between them set nap, abandon the open frame (sdo_oe and hold go to 0) and commit nothing. A third such rise keeps nap.
- R7: A fourth or later conv rise with no sck rise in between sets sleep and clears nap. ref_ready is 0 while sleep is set.
- R8: An sck rise clears nap and sleep. On leaving sleep, ref_ready stays 0 for settle_len clock cycles. The next conv rise then starts a normal frame.
- R9: A conv rise during a frame that has already seen 1 to 15 sck rises pulses proto_err high for one cycle and restarts the frame. The interrupted sample is not committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which all inputs are sampled |
| rst_n | input | 1 | Synchronous active-low reset |
| conv | input | 1 | Convert strobe; a rise starts a conversion or counts as a power command |
| sck | input | 1 | Serial clock; a rise advances the frame and wakes from low power |
| sample_in | input | RES_BITS | Two's-complement word standing in for the analog input |
| settle_len | input | SETTLE_W | Reference settling time after leaving sleep, in clock cycles |
| sdo_data | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Serial output enable; 0 means high impedance |
| hold | output | 1 | Sample/hold is in hold |
| nap | output | 1 | Nap low-power state |
| sleep | output | 1 | Sleep low-power state |
| ref_ready | output | 1 | Reference is settled |
| proto_err | output | 1 | One-cycle flag for a strobe that interrupts a frame |

## Verification
The bench targets the one-conversion lag. A design that sent the current capture would return each sample one frame early, and the very first frame would not be zero. It checks that frames which are abandoned, either by a power command or by an early strobe, commit nothing: a design that committed them would send the wrong word afterwards. It counts the strobe run exactly (two, three, four and five strobes), so an off-by-one would enter nap or sleep one strobe early or late. It times the ready flag after waking and checks the zero padding after the LSB at 12-bit resolution, where a wrong pad width would shift the whole word.

// File: rtl/asm_pkg.sv
// Shared constants and types for the serial converter interface model.
// Assumes a fixed 16-slot frame; resolution is a parameter of the users.
package asm_pkg;
    localparam int FRAME_SLOTS  = 16;
    localparam int NAP_PULSES   = 2;
    localparam int SLEEP_PULSES = 4;
    localparam int PCNT_W       = $clog2(SLEEP_PULSES + 1);

    typedef enum logic [1:0] {
        PWR_RUN   = 2'd0,
        PWR_NAP   = 2'd1,
        PWR_SLEEP = 2'd2
    } pwr_state_t;
endpackage

// File: rtl/asm_rise_det.sv
// Rising-edge detector: one-cycle pulse when sig goes 0 -> 1 between two
// clock samples. Assumes sig is already synchronous to clk.
module asm_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic rise
);
    logic sig_q;

    // Remember last sample of sig.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig;
    end

    assign rise = sig & ~sig_q;
endmodule

// File: rtl/asm_power_ctrl.sv
// Counts strobes seen since the last serial clock rise and derives the
// low-power state, the frame start/cancel decisions and reference readiness.
// Assumes simultaneous strobe and clock rises: the clock clears first.
module asm_power_ctrl #(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                conv_rise,
    input  logic                sck_rise,
    input  logic [SETTLE_W-1:0] settle_len,
    output logic                start,
    output logic                cancel,
    output logic                nap,
    output logic                sleep,
    output logic                ref_ready
);
    import asm_pkg::*;

    logic [PCNT_W-1:0]   pcnt_q, base, pcnt_n;
    pwr_state_t          state_q, state_n;
    logic [SETTLE_W-1:0] settle_q;

    // Strobe count after this cycle's events, and frame decisions.
    always_comb begin
        base   = sck_rise ? '0 : pcnt_q;
        pcnt_n = base;
        if (conv_rise && (base < PCNT_W'(SLEEP_PULSES)))
            pcnt_n = base + PCNT_W'(1);
        start  = conv_rise && (base == '0);
        cancel = conv_rise && (base != '0);
    end

    // Next power state from the updated strobe count.
    always_comb begin
        state_n = sck_rise ? PWR_RUN : state_q;
        if (conv_rise) begin
            if (pcnt_n >= PCNT_W'(SLEEP_PULSES))    state_n = PWR_SLEEP;
            else if (pcnt_n >= PCNT_W'(NAP_PULSES)) state_n = PWR_NAP;
        end
    end

    // Register count, state and the post-sleep settling timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q   <= '0;
            state_q  <= PWR_RUN;
            settle_q <= '0;
        end else begin
            pcnt_q  <= pcnt_n;
            state_q <= state_n;
            if (sck_rise && (state_q == PWR_SLEEP))
                settle_q <= settle_len;
            else if (settle_q != '0)
                settle_q <= settle_q - SETTLE_W'(1);
        end
    end

    assign nap       = (state_q == PWR_NAP);
    assign sleep     = (state_q == PWR_SLEEP);
    assign ref_ready = (state_q != PWR_SLEEP) && (settle_q == '0);
endmodule

// File: rtl/asm_frame_seq.sv
// Frame sequencer: captures the sample on start, shifts the previously
// committed result out one slot per serial clock rise, commits the capture
// after the last slot, and flags strobes that interrupt a running frame.
// Assumes RES_BITS <= FRAME_SLOTS.
module asm_frame_seq #(
    parameter int RES_BITS = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                cancel,
    input  logic                sck_rise,
    input  logic [RES_BITS-1:0] sample_in,
    output logic                sdo_data,
    output logic                active,
    output logic                proto_err
);
    import asm_pkg::*;

    localparam int CNT_W = $clog2(FRAME_SLOTS + 1);
    localparam int PAD   = FRAME_SLOTS - RES_BITS;

    logic [CNT_W-1:0]       cnt_q;
    logic [FRAME_SLOTS-1:0] shreg_q;
    logic [RES_BITS-1:0]    held_q, result_q;
    logic                   active_q, err_q;

    // Frame control, capture, shifting and commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            shreg_q  <= '0;
            held_q   <= '0;
            result_q <= '0;
            active_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            err_q <= start && active_q && (cnt_q != '0);
            if (start) begin
                active_q <= 1'b1;
                cnt_q    <= '0;
                held_q   <= sample_in;
                shreg_q  <= FRAME_SLOTS'(result_q) << PAD;
            end else if (cancel) begin
                active_q <= 1'b0;
            end else if (sck_rise && active_q) begin
                shreg_q <= shreg_q << 1;
                cnt_q   <= cnt_q + CNT_W'(1);
                if (cnt_q == CNT_W'(FRAME_SLOTS - 1)) begin
                    active_q <= 1'b0;
                    result_q <= held_q;
                end
            end
        end
    end

    assign sdo_data  = active_q & shreg_q[FRAME_SLOTS-1];
    assign active    = active_q;
    assign proto_err = err_q;
endmodule

// File: rtl/adc_serial_model.sv
// Top of the serial converter interface model. Detects strobe and clock
// rises, then hands them to the power controller and the frame sequencer.
// Assumes conv and sck are synchronous to clk.
module adc_serial_model #(
    parameter int RES_BITS = 14,
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                conv,
    input  logic                sck,
    input  logic [RES_BITS-1:0] sample_in,
    input  logic [SETTLE_W-1:0] settle_len,
    output logic                sdo_data,
    output logic                sdo_oe,
    output logic                hold,
    output logic                nap,
    output logic                sleep,
    output logic                ref_ready,
    output logic                proto_err
);
    logic conv_rise, sck_rise, start, cancel, active;

    asm_rise_det u_conv_det (.clk(clk), .rst_n(rst_n), .sig(conv), .rise(conv_rise));
    asm_rise_det u_sck_det  (.clk(clk), .rst_n(rst_n), .sig(sck),  .rise(sck_rise));

    asm_power_ctrl #(.SETTLE_W(SETTLE_W)) u_pwr (
        .clk(clk), .rst_n(rst_n), .conv_rise(conv_rise), .sck_rise(sck_rise),
        .settle_len(settle_len), .start(start), .cancel(cancel),
        .nap(nap), .sleep(sleep), .ref_ready(ref_ready)
    );

    asm_frame_seq #(.RES_BITS(RES_BITS)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cancel(cancel),
        .sck_rise(sck_rise), .sample_in(sample_in), .sdo_data(sdo_data),
        .active(active), .proto_err(proto_err)
    );

    assign sdo_oe = active;
    assign hold   = active;
endmodule

// File: rtl/asm_checker.sv
// Protocol checker bound to the top; observes ports only.
module asm_checker (
    input logic clk,
    input logic rst_n,
    input logic conv,
    input logic sck,
    input logic sdo_oe,
    input logic nap,
    input logic sleep,
    input logic ref_ready,
    input logic proto_err
);
    AST_OE_RISE_FROM_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> $past(conv)); // R2
    AST_OE_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdo_oe) |-> ($past(sck) || $past(conv))); // R4
    AST_LOWPWR_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (nap || sleep) |-> !sdo_oe); // R6
    AST_NAP_SLEEP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(nap && sleep)); // R7
    AST_SLEEP_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !ref_ready); // R7
    AST_SCK_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |=> (!nap && !sleep)); // R8
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> !proto_err); // R9
endmodule

bind adc_serial_model asm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .conv(conv), .sck(sck), .sdo_oe(sdo_oe),
    .nap(nap), .sleep(sleep), .ref_ready(ref_ready), .proto_err(proto_err)
);

// File: tb/tb_adc_serial_model.sv
module tb_adc_serial_model;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv = 1'b0;
    logic sck = 1'b0;
    logic [13:0] smp14 = '0;
    logic [11:0] smp12 = '0;
    logic [7:0]  settle = 8'd5;
    logic sdo14, oe14, hold14, nap14, sleep14, rdy14, err14;
    logic sdo12, oe12, hold12, nap12, sleep12, rdy12, err12;
    int total = 0;
    int bad = 0;
    logic [13:0] last14 = '0;
    logic [11:0] last12 = '0;

    always #10 clk = ~clk;

    adc_serial_model #(.RES_BITS(14), .SETTLE_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .conv(conv), .sck(sck), .sample_in(smp14),
        .settle_len(settle), .sdo_data(sdo14), .sdo_oe(oe14), .hold(hold14),
        .nap(nap14), .sleep(sleep14), .ref_ready(rdy14), .proto_err(err14));

    adc_serial_model #(.RES_BITS(12), .SETTLE_W(8)) dut12 (
        .clk(clk), .rst_n(rst_n), .conv(conv), .sck(sck), .sample_in(smp12),
        .settle_len(settle), .sdo_data(sdo12), .sdo_oe(oe12), .hold(hold12),
        .nap(nap12), .sleep(sleep12), .ref_ready(rdy12), .proto_err(err12));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_conv(input logic [13:0] s14, input logic [11:0] s12);
        @(negedge clk); smp14 = s14; smp12 = s12; conv = 1'b1;
        @(negedge clk); conv = 1'b0;
    endtask

    task automatic sck_pulse();
        @(negedge clk); sck = 1'b1;
        @(negedge clk); sck = 1'b0;
    endtask

    // Clock out 16 slots and compare both resolutions against expectations.
    task automatic shift_check(input logic [13:0] e14, input logic [11:0] e12, input string req);
        logic [15:0] g14, g12;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); g14[15-i] = sdo14; g12[15-i] = sdo12; sck = 1'b1;
            @(negedge clk); sck = 1'b0;
        end
        chk({req, " R3 word14"}, {16'h0, g14}, {16'h0, e14, 2'b00});
        chk({req, " R3 word12 pad"}, {16'h0, g12}, {16'h0, e12, 4'h0});
        chk("R4 oe off after 16th", {30'h0, oe14, oe12}, 32'h0);
        chk("R4 hold off after 16th", {30'h0, hold14, hold12}, 32'h0);
    endtask

    task automatic t_reset();
        chk("R1 oe/hold", {28'h0, oe14, hold14, oe12, hold12}, 32'h0);
        chk("R1 nap/sleep/err", {29'h0, nap14, sleep14, err14}, 32'h0);
        chk("R1 ref_ready", {31'h0, rdy14}, 32'h1);
    endtask

    task automatic t_frame(input logic [13:0] s14, input logic [11:0] s12, input string req);
        do_conv(s14, s12);
        chk("R2 oe and hold on", {28'h0, oe14, hold14, oe12, hold12}, 32'hF);
        shift_check(last14, last12, req);
        last14 = s14; last12 = s12;
    endtask

    task automatic t_idle_sck();
        sck_pulse();
        chk("R4 idle sck keeps hi-z", {31'h0, oe14}, 32'h0);
    endtask

    task automatic t_proto_err();
        do_conv(14'h1555, 12'h555);
        for (int i = 0; i < 5; i++) sck_pulse();
        chk("R9 no error yet", {31'h0, err14}, 32'h0);
        do_conv(14'h0AAA, 12'h2AA);
        chk("R9 error pulse", {30'h0, err14, err12}, 32'h3);
        chk("R9 frame restarted", {31'h0, oe14}, 32'h1);
        @(negedge clk);
        chk("R9 error one cycle", {31'h0, err14}, 32'h0);
        shift_check(last14, last12, "R9 R5 interrupted not committed");
        last14 = 14'h0AAA; last12 = 12'h2AA;
    endtask

    task automatic t_powermodes();
        do_conv(14'h3333, 12'h333);
        chk("R6 one strobe no nap", {30'h0, nap14, oe14}, 32'h1);
        do_conv(14'h3333, 12'h333);
        chk("R6 nap after two", {29'h0, nap14, sleep14, oe14}, 32'h4);
        chk("R6 hold released", {31'h0, hold14}, 32'h0);
        do_conv(14'h3333, 12'h333);
        chk("R6 nap after three", {30'h0, nap14, sleep14}, 32'h2);
        do_conv(14'h3333, 12'h333);
        chk("R7 sleep after four", {29'h0, nap14, sleep14, rdy14}, 32'h2);
        do_conv(14'h3333, 12'h333);
        chk("R7 sleep after five", {30'h0, sleep14, oe14}, 32'h2);
        sck_pulse();
        chk("R8 woken", {30'h0, sleep14, nap14}, 32'h0);
        chk("R8 settling", {31'h0, rdy14}, 32'h0);
        repeat (8) @(negedge clk);
        chk("R8 ready after settle", {31'h0, rdy14}, 32'h1);
        t_frame(14'h2468, 12'h468, "R8 R5 after sleep");
        do_conv(14'h1111, 12'h111);
        do_conv(14'h1111, 12'h111);
        chk("R6 nap again", {31'h0, nap14}, 32'h1);
        sck_pulse();
        chk("R8 nap cleared", {30'h0, nap14, rdy14}, 32'h1);
        t_frame(14'h0F0F, 12'hF0F, "R8 R5 after nap");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_frame(14'h2ABC, 12'hABC, "R5 first frame zero");
        t_frame(14'h3F00, 12'h801, "R5 lag");
        t_frame(14'h0001, 12'h7FF, "R3 negative word");
        t_idle_sck();
        t_frame(14'h2000, 12'h001, "R3 positive word");
        t_proto_err();
        t_powermodes();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule